// File: doc/BRIEF.md
# Serial Two-Wire Slave with Outgoing-Data Interrupt

This block is the target side of a two-wire serial link between a host and an on-chip processor. The host drives the serial clock and frames every transfer with start and stop conditions. The block never drives the clock. It pulls the data line low only to acknowledge a byte or to send a zero bit. Bytes the host writes are delivered on an internal strobe-and-data port. Bytes the processor pushes into a small transmit queue are returned when the host reads.

An open-drain, active-low interrupt line is pulled while the transmit queue is not empty. The host answers it by starting a read. The compare address comes from the `cfg_addr` input, and address checking can be switched off with `cfg_chk_en`. The system reset value of the compare address is zero. The serial inputs pass through a synchroniser into a faster system clock domain. All edge, start and stop detection uses the synchronised samples.

The controller has these states:
- IDLE: waits for a start.
- ADDR: shifts in the address byte.
- AACK: drives the address acknowledge.
- WDATA: shifts in a write byte.
- WACK: drives the write acknowledge.
- RDATA: shifts out a read byte.
- RACK: samples the host acknowledge.
- SKIP: ignores the bus until the next start or stop.

The transitions are:
- A start moves any state to ADDR.
- A stop moves any state to IDLE.
- ADDR goes to AACK when the address is accepted, and to SKIP otherwise.
- AACK goes to WDATA when the direction bit is 0, and to RDATA when it is 1.
- WDATA goes to WACK.
- WACK goes to WDATA.
- RDATA goes to RACK.
- RACK goes to RDATA when the host acknowledges, and to SKIP when it does not.

Top module: `i2c_req_slave`

## Requirements
- R1: After reset the block pulls neither the data line nor the interrupt line, `rx_valid` is low and `tx_full` is low.
- R2: With `cfg_chk_en`=1, the block acknowledges an address byte (7-bit address, MSB first, then a direction bit where 0=write and 1=read) by holding the data line low during the ninth clock only if the address equals `cfg_addr`. On a mismatch it gives no acknowledge, delivers no byte and acknowledges nothing until the next start.
- R3: With `cfg_chk_en`=0, every address is acknowledged.
- R4: In a write, each byte is sampled MSB first on rising clock edges. It appears on `rx_data` with a one-cycle `rx_valid` pulse and is acknowledged during the ninth clock.
- R5: In a read, queued bytes are shifted out MSB first, in the order they were pushed.
- R6: A byte leaves the queue only after all eight of its bits have been sent. A host not-acknowledge ends the read, and the bytes not yet sent stay queued.
- R7: `irq_pull` is 1 exactly while the transmit queue holds at least one byte.
- R8: A push while the queue is full is ignored, and `tx_full` is 1 while the queue holds `FIFO_DEPTH` bytes.
- R9: A read with an empty queue returns 8'hFF, because the data line is released.
- R10: A start that arrives in the middle of a byte aborts the transfer without delivering the partial byte and begins a new address phase.
- R11: After a stop the block does not pull the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Sampled level of the shared data line |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain) |
| irq_pull | output | 1 | 1 pulls the interrupt line low (open-drain) |
| cfg_addr | input | 7 | Compare address |
| cfg_chk_en | input | 1 | 1 enables address checking |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to queue for reading |
| tx_full | output | 1 | Transmit queue is full |

## Verification
The assertions assume a few things about the host:
- It holds each clock phase for many system cycles.
- It changes the data line only while the clock has been low for several cycles.
- It never raises a start or stop while the slave is pulling the line.

Under these conditions the slave takes the line only during a low clock phase, and each acknowledge follows its received byte. The bench host keeps to this. It uses phases of eight system cycles and moves data four cycles after each falling clock edge. Random transfers pick their addresses, lengths and bytes with `$urandom` from a fixed seed. Directed cases cover a mismatched address, a queue overflow, an empty read and a start inside a byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } i2cs_state_t;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DEV_ADDR_W = 7;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // STAGES flops for synchronisation plus one for edge history
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;
    logic scl_s;
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign scl_q     = scl_p[STAGES];
    assign sda_s     = sda_p[STAGES-1];
    assign sda_q     = sda_p[STAGES];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0] CNT_FULL = (AW + 1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   count;
    logic          push_ok;
    logic          pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_req_slave.sv
module i2c_req_slave
    import i2cs_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull,
    output logic                  irq_pull,
    input  logic [DEV_ADDR_W-1:0] cfg_addr,
    input  logic                  cfg_chk_en,
    output logic                  rx_valid,
    output logic [BYTE_W-1:0]     rx_data,
    input  logic                  tx_push,
    input  logic [BYTE_W-1:0]     tx_data,
    output logic                  tx_full
);
    localparam logic [3:0] BITS_DONE = 4'(BYTE_W);

    i2cs_state_t       state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              host_ack;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic fifo_empty, fifo_full, pop;
    logic [BYTE_W-1:0] fifo_head, tx_head;
    logic addr_ok;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (tx_data),
        .pop   (pop),
        .head  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // an empty queue sends all ones: the line stays released
    assign tx_head = fifo_empty ? '1 : fifo_head;
    assign addr_ok = !cfg_chk_en || (shreg[BYTE_W-1:1] == cfg_addr);
    // pop only once the eighth bit has been clocked out
    assign pop = (state == ST_RDATA) && scl_fall && !start_det && !stop_det
                 && (bit_cnt == BITS_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: begin
                    end
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BITS_DONE) begin
                            rw    <= shreg[0];
                            state <= addr_ok ? ST_AACK : ST_SKIP;
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                state <= ST_RDATA;
                                shreg <= tx_head;
                            end else begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BITS_DONE) begin
                            rx_data  <= shreg;
                            rx_valid <= 1'b1;
                            state    <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            state   <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == BITS_DONE) begin
                                state <= ST_RACK;
                            end else begin
                                shreg <= {shreg[BYTE_W-2:0], 1'b1};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                state   <= ST_RDATA;
                                shreg   <= tx_head;
                                bit_cnt <= '0;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            ST_AACK, ST_WACK: sda_pull = 1'b1;
            ST_RDATA:         sda_pull = ~shreg[BYTE_W-1];
            default:          sda_pull = 1'b0;
        endcase
        irq_pull = ~fifo_empty;
        tx_full  = fifo_full;
    end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_pull,
    input logic irq_pull,
    input logic rx_valid,
    input logic tx_push,
    input logic tx_full
);
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_i); // R2
    AST_ACK_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sda_pull); // R4
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_IRQ_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_full) |=> irq_pull); // R7
    AST_FULL_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_full) |-> $past(tx_push)); // R8
    AST_FULL_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> irq_pull); // R8
endmodule

bind i2c_req_slave i2cs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_pull (sda_pull),
    .irq_pull (irq_pull),
    .rx_valid (rx_valid),
    .tx_push  (tx_push),
    .tx_full  (tx_full)
);

// File: tb/i2c_req_slave_tb.sv
module i2c_req_slave_tb;
    localparam int DEPTH = 4;
    localparam int PH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic sda_line;
    logic sda_pull, irq_pull, rx_valid, tx_full;
    logic [7:0] rx_data;
    logic [6:0] cfg_addr = 7'd0;
    logic cfg_chk_en = 1'b1;
    logic tx_push = 1'b0;
    logic [7:0] tx_data = 8'd0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] rx_log[$];
    logic [7:0] exp_rx[$];
    logic [7:0] model_q[$];

    always #2 clk = ~clk;
    assign sda_line = sda_h & ~sda_pull;

    i2c_req_slave #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull(sda_pull), .irq_pull(irq_pull),
        .cfg_addr(cfg_addr), .cfg_chk_en(cfg_chk_en),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full)
    );

    always @(posedge clk) if (rx_valid) rx_log.push_back(rx_data);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_ack(logic [6:0] a);
        return !cfg_chk_en || (a == cfg_addr);
    endfunction

    function automatic logic [7:0] exp_read();
        if (model_q.size() == 0) return 8'hFF;
        return model_q.pop_front();
    endfunction

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; wait_n(PH/2);
        sda_h = 1'b1; wait_n(PH/2);
        scl = 1'b1; wait_n(PH);
        sda_h = 1'b0; wait_n(PH);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(PH/2); sda_h = 1'b0; wait_n(PH/2);
        scl = 1'b1; wait_n(PH);
        sda_h = 1'b1; wait_n(PH);
    endtask

    task automatic bit_out(logic b);
        wait_n(PH/2); sda_h = b; wait_n(PH/2);
        scl = 1'b1; wait_n(PH);
        scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        wait_n(PH/2); sda_h = 1'b1; wait_n(PH/2);
        scl = 1'b1; wait_n(PH/2);
        b = sda_line; wait_n(PH/2);
        scl = 1'b0;
    endtask

    task automatic write_byte(logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(s);
        ack = ~s;
    endtask

    task automatic read_byte(logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(~give_ack);
    endtask

    task automatic push(logic [7:0] v);
        @(negedge clk); tx_push = 1'b1; tx_data = v;
        @(negedge clk); tx_push = 1'b0;
        if (model_q.size() < DEPTH) model_q.push_back(v);
    endtask

    task automatic check_rx(string req);
        wait_n(4);
        chk({req, " count"}, rx_log.size(), exp_rx.size());
        while (exp_rx.size() > 0 && rx_log.size() > 0)
            chk({req, " byte"}, rx_log.pop_front(), exp_rx.pop_front());
        rx_log.delete(); exp_rx.delete();
    endtask

    // full write transaction with expected acks from the address model
    task automatic write_txn(logic [6:0] a, int n, string req);
        logic ack;
        bit e;
        e = exp_ack(a);
        bus_start();
        write_byte({a, 1'b0}, ack);
        chk({req, " addr ack"}, ack, e);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            write_byte(d, ack);
            chk({req, " data ack"}, ack, e);
            if (e) exp_rx.push_back(d);
        end
        bus_stop();
        chk("R11 released after stop", sda_pull, 1'b0);
        check_rx(req);
    endtask

    task automatic read_txn(int n, string req);
        logic ack;
        logic [7:0] v;
        bus_start();
        write_byte({cfg_addr, 1'b1}, ack);
        chk({req, " read addr ack"}, ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, v);
            chk({req, " read byte"}, v, exp_read());
        end
        bus_stop();
        wait_n(4);
        chk("R7 irq after read", irq_pull, model_q.size() != 0);
    endtask

    initial begin
        int unused_seed;
        logic ack;
        logic [7:0] v;
        unused_seed = $urandom(32'd4711);
        wait_n(5);
        chk("R1 sda", sda_pull, 1'b0);
        chk("R1 irq", irq_pull, 1'b0);
        chk("R1 rx_valid", rx_valid, 1'b0);
        chk("R1 full", tx_full, 1'b0);
        rst_n = 1'b1;
        wait_n(4);

        // R2 reset-value address zero matches; R4 writes
        write_txn(7'd0, 3, "R4 write addr0");
        write_txn(7'h21, 2, "R2 mismatch");
        cfg_chk_en = 1'b0;
        write_txn(7'h5A, 2, "R3 check off");
        cfg_chk_en = 1'b1;
        cfg_addr = 7'h3C;

        // R5/R6/R7 queue and read order, NACK leaves remainder
        push(8'hA5); push(8'h3C); push(8'h81);
        wait_n(2);
        chk("R7 irq with data", irq_pull, 1'b1);
        read_txn(2, "R5 R6");
        chk("R6 remainder queued", irq_pull, 1'b1);
        read_txn(1, "R5");
        chk("R7 irq empty", irq_pull, 1'b0);

        // R9 empty read
        read_txn(1, "R9 empty");

        // R8 overflow
        for (int i = 0; i < DEPTH + 1; i++) push(8'(8'h10 + i));
        wait_n(2);
        chk("R8 full", tx_full, 1'b1);
        read_txn(DEPTH + 1, "R8 drop");
        chk("R8 not full", tx_full, 1'b0);

        // R10 start inside a byte
        bus_start();
        write_byte({cfg_addr, 1'b0}, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_start();
        write_byte({cfg_addr, 1'b0}, ack);
        chk("R10 new addr ack", ack, 1'b1);
        v = 8'h6E;
        write_byte(v, ack);
        exp_rx.push_back(v);
        bus_stop();
        check_rx("R10");

        // random mix
        for (int it = 0; it < 14; it++) begin
            int mode;
            mode = int'($urandom % 3);
            if (mode == 0) begin
                cfg_chk_en = 1'($urandom);
                write_txn(($urandom % 2) ? cfg_addr : 7'($urandom), 1 + int'($urandom % 3), "R2 R3 R4 rand");
                cfg_chk_en = 1'b1;
            end else begin
                int np;
                np = int'($urandom % 4);
                for (int k = 0; k < np; k++) push(8'($urandom));
                read_txn(1 + int'($urandom % 3), "R5 R9 rand");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule